// File: doc/BRIEF.md
# Module Local Space Router

This block sits between a host-side access path and four plug-in module slots. A host access arrives tagged with one of three local windows: a small register window, a 16-bit memory window or an 8-bit memory window. The block splits the address into a slot number, a space code and an offset, with a different split for each window. It then fires a one-cycle strobe at the chosen slot, and it returns the slot's read data one cycle after that strobe.

The register window and the 16-bit memory window can each be set to big-endian operation. In that mode a byte access has its lowest address bit inverted, and 16-bit data has its two bytes exchanged in both directions. The 8-bit memory window never applies this correction. A third flag is kept for a control window that is decoded elsewhere, and it leaves the block on its own pin. The host writes and reads back all three flags through a byte-wide configuration port.

A slot that reports no module gets no strobe. Reads aimed at it return zero, and writes aimed at it are dropped.

Top module: `local_space_router`

## Requirements
- R1: In the register window (`req_win`=0), address bits [9:8] give the slot and bits [7:6] give the space. Value 2 selects ID (`slot_space`=1), value 3 selects INT (`slot_space`=2), and values 0 and 1 select I/O (`slot_space`=0).
- R2: The offset is the address masked to 7 bits for I/O space and to 6 bits for ID and INT space, zero-extended to 23 bits.
- R3: In the 16-bit memory window (`req_win`=1), the slot is address bits [24:23] and the offset is bits [22:0]; `slot_space` is 3.
- R4: In the 8-bit memory window (`req_win`=2), the slot is address bits [23:22] and the offset is bits [21:0]; `slot_space` is 4. Bit 24 is ignored. Every access is byte wide whatever `req_wide` says, and no endian correction is applied.
- R5: When a window's big-endian flag is 1, a byte access in that window has address bit 0 inverted before the split.
- R6: When a window's big-endian flag is 1, 16-bit write data reaches the slot with its bytes exchanged, and 16-bit read data is returned with its bytes exchanged.
- R7: An access to a slot whose `slot_present` bit is 0, or with `req_win`=3, raises no strobe. A read of that kind still responds, with data zero.
- R8: A request accepted at a clock edge raises exactly one `slot_stb` bit for the following cycle. A read gets `rsp_valid` one cycle after its strobe, and a write gets no response.
- R9: Configuration bytes 0x2B, 0x2F and 0x33 hold, in bit 0, the big-endian flags for the control window, the register window and the 16-bit memory window. They read back as that bit. Every other configuration byte reads as zero, and writes to other bytes are ignored.
- R10: Reset clears all three flags to little-endian (0) and leaves no strobe and no response pending.
- R11: A byte write drives the low data byte with the upper byte zero. A byte read returns the slot's low byte, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access valid this cycle |
| req_win | input | 2 | Window: 0 register, 1 16-bit memory, 2 8-bit memory, 3 unused |
| req_we | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| req_addr | input | 25 | Byte address within the window |
| req_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |
| cfg_we | input | 1 | Configuration byte write |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wflag | input | 1 | Bit 0 of the written configuration byte |
| cfg_rdata | output | 8 | Configuration byte read data (combinational) |
| ctrl_big_endian | output | 1 | Big-endian flag of the control window |
| slot_present | input | 4 | Module present, one bit per slot |
| slot_stb | output | 4 | One-cycle access strobe, one bit per slot |
| slot_space | output | 3 | Space code: 0 I/O, 1 ID, 2 INT, 3 16-bit memory, 4 8-bit memory |
| slot_offset | output | 23 | Masked offset within the space |
| slot_we | output | 1 | Access is a write |
| slot_wide | output | 1 | Access is 16-bit |
| slot_wdata | output | 16 | Write data after lane correction |
| slot_rdata | input | 64 | Read data, 16 bits per slot, slot 0 in the low bits |

## Verification
Some properties are checked on every cycle. At most one strobe is high at a time. A strobe only reaches a slot that was present when the request was taken. Offsets never carry bits above the mask of their space. The 8-bit memory window never issues a wide access. Reads and responses keep a fixed two-cycle spacing, and writes never produce a response.

The actual address splits, the byte-lane exchange, the inverted byte address and the zero returned from empty slots can only be shown by the bench's scenarios. The same holds for the independence of the three endian flags and their return to zero at reset. The bench compares each of these against values it works out itself from the requirements.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        WIN_REG   = 2'd0,
        WIN_MEM16 = 2'd1,
        WIN_MEM8  = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        SP_IO    = 3'd0,
        SP_ID    = 3'd1,
        SP_INT   = 3'd2,
        SP_MEM16 = 3'd3,
        SP_MEM8  = 3'd4
    } space_e;

    // flag index within the endian configuration bits
    localparam int FLAG_CTRL  = 0;
    localparam int FLAG_REG   = 1;
    localparam int FLAG_MEM16 = 2;
    localparam int FLAG_N     = 3;

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
    import lsr_pkg::*;
#(
    parameter int SLOT_W          = 2,
    parameter int ADDR_W          = 25,
    parameter int OFF_W           = 23,
    parameter int REG_SLOT_SHIFT  = 8,
    parameter int REG_SPACE_SHIFT = 6,
    parameter int IO_OFF_W        = 7,
    parameter int IDI_OFF_W       = 6,
    parameter int MEM16_SHIFT     = 23,
    parameter int MEM8_SHIFT      = 22
) (
    input  logic [1:0]        win,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic              be_reg,
    input  logic              be_m16,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output space_e            space,
    output logic [OFF_W-1:0]  off,
    output logic              byte_acc,
    output logic              swap
);
    logic              be;
    logic [ADDR_W-1:0] a;

    always_comb begin
        byte_acc = !wide || (win == WIN_MEM8);
        case (win)
            WIN_REG:   be = be_reg;
            WIN_MEM16: be = be_m16;
            default:   be = 1'b0;
        endcase
        a    = addr;
        a[0] = addr[0] ^ (be && byte_acc);
        swap = be && !byte_acc;

        hit   = 1'b1;
        slot  = '0;
        space = SP_IO;
        off   = '0;
        case (win)
            WIN_REG: begin
                slot = a[REG_SLOT_SHIFT +: SLOT_W];
                case (a[REG_SPACE_SHIFT +: 2])
                    2'd2: begin
                        space = SP_ID;
                        off   = OFF_W'(a[IDI_OFF_W-1:0]);
                    end
                    2'd3: begin
                        space = SP_INT;
                        off   = OFF_W'(a[IDI_OFF_W-1:0]);
                    end
                    default: begin
                        space = SP_IO;
                        off   = OFF_W'(a[IO_OFF_W-1:0]);
                    end
                endcase
            end
            WIN_MEM16: begin
                slot  = a[MEM16_SHIFT +: SLOT_W];
                space = SP_MEM16;
                off   = OFF_W'(a[MEM16_SHIFT-1:0]);
            end
            WIN_MEM8: begin
                slot  = a[MEM8_SHIFT +: SLOT_W];
                space = SP_MEM8;
                off   = OFF_W'(a[MEM8_SHIFT-1:0]);
            end
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsr_swap.sv
module lsr_swap #(
    parameter int DATA_W = 16,
    localparam int NB    = DATA_W / 8
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
    end
endmodule

// File: rtl/lsr_cfg.sv
module lsr_cfg
    import lsr_pkg::*;
#(
    parameter int CFG_AW     = 8,
    parameter int CFG_BASE   = 'h2B,
    parameter int CFG_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_wflag,
    output logic [7:0]        cfg_rdata,
    output logic [FLAG_N-1:0] flags
);
    logic [FLAG_N-1:0] match;
    logic [FLAG_N-1:0] flags_d, flags_q;

    for (genvar k = 0; k < FLAG_N; k++) begin : g_match
        assign match[k] = (cfg_addr == CFG_AW'(CFG_BASE + k * CFG_STRIDE));
    end

    always_comb begin
        flags_d = flags_q;
        for (int k = 0; k < FLAG_N; k++) begin
            if (cfg_we && match[k]) flags_d[k] = cfg_wflag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign cfg_rdata = {7'b0, |(match & flags_q)};
    assign flags     = flags_q;
endmodule

// File: rtl/local_space_router.sv
module local_space_router
    import lsr_pkg::*;
#(
    parameter int N_SLOTS          = 4,
    parameter int DATA_W           = 16,
    parameter int CFG_AW           = 8,
    parameter int MEM16_SHIFT      = 23,
    parameter int MEM8_SHIFT       = 22,
    parameter int REG_SLOT_SHIFT   = 8,
    parameter int REG_SPACE_SHIFT  = 6,
    parameter int IO_OFF_W         = 7,
    parameter int IDI_OFF_W        = 6,
    localparam int SLOT_W          = $clog2(N_SLOTS),
    localparam int ADDR_W          = MEM16_SHIFT + SLOT_W,
    localparam int OFF_W           = MEM16_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_win,
    input  logic                      req_we,
    input  logic                      req_wide,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic                      cfg_wflag,
    output logic [7:0]                cfg_rdata,
    output logic                      ctrl_big_endian,
    input  logic [N_SLOTS-1:0]        slot_present,
    output logic [N_SLOTS-1:0]        slot_stb,
    output logic [2:0]                slot_space,
    output logic [OFF_W-1:0]          slot_offset,
    output logic                      slot_we,
    output logic                      slot_wide,
    output logic [DATA_W-1:0]         slot_wdata,
    input  logic [N_SLOTS*DATA_W-1:0] slot_rdata
);
    typedef struct packed {
        logic              stb;
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [OFF_W-1:0]  off;
        logic              we;
        logic              wide;
        logic [DATA_W-1:0] wdata;
        logic              rd;
        logic              rd_hit;
        logic              rd_swap;
        logic              rd_byte;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
    } st_t;

    st_t st_d, st_q;

    logic [FLAG_N-1:0] flags;
    logic              dec_hit, dec_byte, dec_swap;
    logic [SLOT_W-1:0] dec_slot;
    space_e            dec_space;
    logic [OFF_W-1:0]  dec_off;
    logic [DATA_W-1:0] wdata_sw, rd_sel, rd_sw;

    lsr_cfg #(.CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wflag(cfg_wflag), .cfg_rdata(cfg_rdata), .flags(flags)
    );

    lsr_decode #(
        .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .REG_SLOT_SHIFT(REG_SLOT_SHIFT), .REG_SPACE_SHIFT(REG_SPACE_SHIFT),
        .IO_OFF_W(IO_OFF_W), .IDI_OFF_W(IDI_OFF_W),
        .MEM16_SHIFT(MEM16_SHIFT), .MEM8_SHIFT(MEM8_SHIFT)
    ) u_dec (
        .win(req_win), .wide(req_wide), .addr(req_addr),
        .be_reg(flags[FLAG_REG]), .be_m16(flags[FLAG_MEM16]),
        .hit(dec_hit), .slot(dec_slot), .space(dec_space), .off(dec_off),
        .byte_acc(dec_byte), .swap(dec_swap)
    );

    lsr_swap #(.DATA_W(DATA_W)) u_wr_swap (.din(req_wdata), .dout(wdata_sw));

    assign rd_sel = slot_rdata[st_q.slot*DATA_W +: DATA_W];
    lsr_swap #(.DATA_W(DATA_W)) u_rd_swap (.din(rd_sel), .dout(rd_sw));

    always_comb begin
        st_d       = st_q;
        st_d.stb   = req_valid && dec_hit && slot_present[dec_slot];
        st_d.slot  = dec_slot;
        st_d.space = dec_space;
        st_d.off   = dec_off;
        st_d.we    = req_we;
        st_d.wide  = !dec_byte;
        if (dec_byte)      st_d.wdata = {{(DATA_W-8){1'b0}}, req_wdata[7:0]};
        else if (dec_swap) st_d.wdata = wdata_sw;
        else               st_d.wdata = req_wdata;
        st_d.rd      = req_valid && !req_we;
        st_d.rd_hit  = st_d.stb;
        st_d.rd_swap = dec_swap;
        st_d.rd_byte = dec_byte;

        // response stage: one cycle behind the strobe
        st_d.rsp_v = st_q.rd;
        if (!st_q.rd || !st_q.rd_hit) st_d.rsp_d = '0;
        else if (st_q.rd_byte)        st_d.rsp_d = {{(DATA_W-8){1'b0}}, rd_sel[7:0]};
        else if (st_q.rd_swap)        st_d.rsp_d = rd_sw;
        else                          st_d.rsp_d = rd_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_stb
        assign slot_stb[s] = st_q.stb && (st_q.slot == SLOT_W'(s));
    end

    assign slot_space      = st_q.space;
    assign slot_offset     = st_q.off;
    assign slot_we         = st_q.we;
    assign slot_wide       = st_q.wide;
    assign slot_wdata      = st_q.wdata;
    assign rsp_valid       = st_q.rsp_v;
    assign rsp_rdata       = st_q.rsp_d;
    assign ctrl_big_endian = flags[FLAG_CTRL];
endmodule

// File: rtl/lsr_chk.sv
module lsr_chk
    import lsr_pkg::*;
#(
    parameter int N_SLOTS    = 4,
    parameter int OFF_W      = 23,
    parameter int IO_OFF_W   = 7,
    parameter int IDI_OFF_W  = 6,
    parameter int MEM8_SHIFT = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_we,
    input logic               rsp_valid,
    input logic [N_SLOTS-1:0] slot_present,
    input logic [N_SLOTS-1:0] slot_stb,
    input logic [2:0]         slot_space,
    input logic [OFF_W-1:0]   slot_offset,
    input logic               slot_wide
);
    assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_stb));

    assert_stb_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_stb) |-> $past(req_valid));

    assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we) |=> ##1 rsp_valid);

    assert_rsp_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_we, 2));

    assert_stb_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_stb) |-> ((slot_stb & $past(slot_present)) == slot_stb));

    assert_io_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|slot_stb) && slot_space == SP_IO) |-> ((slot_offset >> IO_OFF_W) == '0));

    assert_idint_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|slot_stb) && (slot_space == SP_ID || slot_space == SP_INT))
        |-> ((slot_offset >> IDI_OFF_W) == '0));

    assert_mem8_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|slot_stb) && slot_space == SP_MEM8)
        |-> (!slot_wide && ((slot_offset >> MEM8_SHIFT) == '0)));
endmodule

bind local_space_router lsr_chk #(
    .N_SLOTS(N_SLOTS), .OFF_W(OFF_W), .IO_OFF_W(IO_OFF_W),
    .IDI_OFF_W(IDI_OFF_W), .MEM8_SHIFT(MEM8_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .rsp_valid(rsp_valid), .slot_present(slot_present), .slot_stb(slot_stb),
    .slot_space(slot_space), .slot_offset(slot_offset), .slot_wide(slot_wide)
);

// File: tb/tb_local_space_router.sv
module tb_local_space_router;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_we, req_wide;
    logic [1:0]  req_win;
    logic [24:0] req_addr;
    logic [15:0] req_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        cfg_we, cfg_wflag;
    logic [7:0]  cfg_addr, cfg_rdata;
    logic        ctrl_big_endian;
    logic [3:0]  slot_present, slot_stb;
    logic [2:0]  slot_space;
    logic [22:0] slot_offset;
    logic        slot_we, slot_wide;
    logic [15:0] slot_wdata;
    logic [63:0] slot_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    local_space_router dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
        .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wflag(cfg_wflag),
        .cfg_rdata(cfg_rdata), .ctrl_big_endian(ctrl_big_endian),
        .slot_present(slot_present), .slot_stb(slot_stb),
        .slot_space(slot_space), .slot_offset(slot_offset), .slot_we(slot_we),
        .slot_wide(slot_wide), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata)
    );

    // slot model: each slot answers {slot number, low 12 offset bits}
    for (genvar i = 0; i < 4; i++) begin : g_slot
        assign slot_rdata[i*16 +: 16] = {4'(i), slot_offset[11:0]};
    end

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  win;
        logic        we;
        logic        wide;
        logic [24:0] addr;
        logic [15:0] wd;
        logic [2:0]  eslot;   // 3'b100 = no strobe expected
        logic [2:0]  esp;
        logic [22:0] eoff;
        logic [15:0] ewd;
        logic [15:0] erd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        {4'd1,  2'd0, 1'b0, 1'b1, 25'h00001C5, 16'h0000, 3'd1, 3'd2, 23'h000005, 16'h0000, 16'h1005}, // R1 INT
        {4'd2,  2'd0, 1'b0, 1'b0, 25'h00000BF, 16'h0000, 3'd0, 3'd1, 23'h00003F, 16'h0000, 16'h003F}, // R2 ID
        {4'd2,  2'd0, 1'b1, 1'b1, 25'h000037F, 16'hA55A, 3'd3, 3'd0, 23'h00007F, 16'hA55A, 16'h0000}, // R2 IO
        {4'd1,  2'd0, 1'b0, 1'b1, 25'h00003FF, 16'h0000, 3'd3, 3'd2, 23'h00003F, 16'h0000, 16'h303F}, // R1
        {4'd1,  2'd0, 1'b0, 1'b1, 25'h0000025, 16'h0000, 3'd0, 3'd0, 23'h000025, 16'h0000, 16'h0025}, // R1 IO
        {4'd3,  2'd1, 1'b0, 1'b1, 25'h1ABCDEF, 16'h0000, 3'd3, 3'd3, 23'h2BCDEF, 16'h0000, 16'h3DEF}, // R3
        {4'd3,  2'd1, 1'b1, 1'b1, 25'h0812345, 16'h1234, 3'd1, 3'd3, 23'h012345, 16'h1234, 16'h0000}, // R3
        {4'd7,  2'd1, 1'b0, 1'b1, 25'h1000010, 16'h0000, 3'd4, 3'd0, 23'h000000, 16'h0000, 16'h0000}, // R7
        {4'd4,  2'd2, 1'b0, 1'b1, 25'h0C00123, 16'h0000, 3'd3, 3'd4, 23'h000123, 16'h0000, 16'h0023}, // R4
        {4'd4,  2'd2, 1'b1, 1'b1, 25'h1400002, 16'hBEEF, 3'd1, 3'd4, 23'h000002, 16'h00EF, 16'h0000}, // R4
        {4'd7,  2'd0, 1'b1, 1'b1, 25'h0000200, 16'h5555, 3'd4, 3'd0, 23'h000000, 16'h0000, 16'h0000}, // R7
        {4'd7,  2'd3, 1'b0, 1'b1, 25'h0000000, 16'h0000, 3'd4, 3'd0, 23'h000000, 16'h0000, 16'h0000}, // R7
        {4'd11, 2'd0, 1'b1, 1'b0, 25'h0000101, 16'h12AB, 3'd1, 3'd0, 23'h000001, 16'h00AB, 16'h0000}  // R11
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] w, input logic we, input logic wide,
                          input logic [24:0] a, input logic [15:0] wd,
                          input logic [2:0] es, input logic [2:0] esp,
                          input logic [22:0] eo, input logic [15:0] ewd,
                          input logic [15:0] erd, input string tag);
        logic [3:0] exp_stb;
        exp_stb = es[2] ? 4'b0 : (4'b1 << es[1:0]);
        @(negedge clk);
        req_valid = 1'b1; req_win = w; req_we = we; req_wide = wide;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "strobe", 32'(slot_stb), 32'(exp_stb));
        if (!es[2]) begin
            check(tag, "space", 32'(slot_space), 32'(esp));
            check(tag, "offset", 32'(slot_offset), 32'(eo));
            check(tag, "we", 32'(slot_we), 32'(we));
            if (we) check(tag, "wdata", 32'(slot_wdata), 32'(ewd));
        end
        @(negedge clk);
        check(tag, "rsp_valid", 32'(rsp_valid), 32'(!we));
        if (!we) check(tag, "rdata", 32'(rsp_rdata), 32'(erd));
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic f);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wflag = f;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, $sformatf("cfg[%h]", a), 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_win = 2'd0; req_we = 1'b0;
        req_wide = 1'b0; req_addr = '0; req_wdata = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wflag = 1'b0;
        slot_present = 4'b1011;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "strobe in reset", 32'(slot_stb), 32'h0);
        check("R10", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        cfg_check(8'h2B, 8'h00, "R10");
        cfg_check(8'h2F, 8'h00, "R10");
        cfg_check(8'h33, 8'h00, "R10");

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].win, VECS[i].we, VECS[i].wide, VECS[i].addr, VECS[i].wd,
                   VECS[i].eslot, VECS[i].esp, VECS[i].eoff, VECS[i].ewd, VECS[i].erd,
                   $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R9: register window flag, readback and ignored bytes
        cfg_write(8'h2F, 1'b1);
        cfg_check(8'h2F, 8'h01, "R9");
        cfg_check(8'h2B, 8'h00, "R9");
        cfg_check(8'h33, 8'h00, "R9");
        cfg_write(8'h2C, 1'b1);
        cfg_check(8'h2C, 8'h00, "R9");
        cfg_check(8'h33, 8'h00, "R9");

        // R5: byte address flip in register window
        access(2'd0, 1'b0, 1'b0, 25'h1C5, 16'h0, 3'd1, 3'd2, 23'h4, 16'h0, 16'h0004, "R5");
        // R6: 16-bit swap both directions in register window
        access(2'd0, 1'b0, 1'b1, 25'h1C4, 16'h0, 3'd1, 3'd2, 23'h4, 16'h0, 16'h0410, "R6");
        access(2'd0, 1'b1, 1'b1, 25'h1C4, 16'h1234, 3'd1, 3'd2, 23'h4, 16'h3412, 16'h0, "R6");
        // R11 with R5: byte write after flip keeps low byte only
        access(2'd0, 1'b1, 1'b0, 25'h101, 16'h77AB, 3'd1, 3'd0, 23'h0, 16'h00AB, 16'h0, "R11");
        // R9: memory window unaffected by register window flag
        access(2'd1, 1'b0, 1'b1, 25'h0800006, 16'h0, 3'd1, 3'd3, 23'h6, 16'h0, 16'h1006, "R9");

        cfg_write(8'h33, 1'b1);
        cfg_check(8'h33, 8'h01, "R9");
        access(2'd1, 1'b0, 1'b1, 25'h0800006, 16'h0, 3'd1, 3'd3, 23'h6, 16'h0, 16'h0610, "R6");
        access(2'd1, 1'b0, 1'b0, 25'h0800007, 16'h0, 3'd1, 3'd3, 23'h6, 16'h0, 16'h0006, "R5");

        cfg_write(8'h2B, 1'b1);
        cfg_check(8'h2B, 8'h01, "R9");
        checks++;
        if (ctrl_big_endian !== 1'b1) begin
            fails++;
            $display("FAIL R9 ctrl_big_endian actual=%b expected=1", ctrl_big_endian);
        end
        // R4: 8-bit window ignores all flags
        access(2'd2, 1'b0, 1'b0, 25'h0C00123, 16'h0, 3'd3, 3'd4, 23'h123, 16'h0, 16'h0023, "R4");

        // R10: reset returns flags to little-endian
        do_reset();
        cfg_check(8'h2F, 8'h00, "R10");
        cfg_check(8'h33, 8'h00, "R10");
        cfg_check(8'h2B, 8'h00, "R10");
        access(2'd0, 1'b0, 1'b1, 25'h1C4, 16'h0, 3'd1, 3'd2, 23'h4, 16'h0, 16'h1004, "R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule